// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM

This block is a single-clock static RAM. Address, write data, chip selects and write controls are all captured on the rising clock edge. A read returns its word through an output register, so the path from address to data has two register stages. A write can update any one to four of the four byte lanes of a 32-bit word. A global-write input overrides the lane enables and updates the whole word.

Three chip-select inputs allow depth expansion and address pipelining. The block accepts a request only when all three are at their active levels. The output enable is asynchronous. It gates the pad driver directly, so the pad can release the shared data bus without waiting for a clock. The shared bus is split here into an input word, an output word and a drive-enable, and the pad ring joins them into the common bidirectional bus.

A sleep input blocks all requests and releases the bus. Once sleep is released, the block stays in a wake-up window for a fixed number of clock edges before it accepts requests again. The stored contents are kept throughout. The depth is a parameter, so it can be made small for simulation.

Top module: `pipe_bw_sram`

## Requirements
- R1: After reset, `dq_oe` is low, no request is pending, and the block accepts requests straight away (it is not in the wake-up window).
- R2: When `byte_wr_en_n` is low, each low bit `byte_wr_n[i]` writes only data bits `8*i+7 : 8*i`. Lane 0 covers bits 7:0 and lane 3 covers bits 31:24. All other bytes of the word keep their values.
- R3: When `byte_wr_en_n` is high and `glob_wr_n` is high, `byte_wr_n` has no effect. The cycle is a read and the memory is unchanged.
- R4: A low `glob_wr_n` writes all four bytes, whatever `byte_wr_en_n` and `byte_wr_n` are.
- R5: A read sampled on rising edge k drives its word on `dq_o` with `dq_oe` high after edge k+1. Write cycles and idle cycles leave `dq_oe` low in their output slot.
- R6: `dq_oe` is low whenever `oe_n` is high. It follows `oe_n` with no clock edge in between.
- R7: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A deselected cycle writes nothing, and its output slot has `dq_oe` low.
- R8: While `sleep` is high, no request is accepted and `dq_oe` is low at once.
- R9: After `sleep` falls, requests sampled on the next three rising edges are ignored. The fourth edge accepts a request.
- R10: Memory contents are kept through sleep and the wake-up window.
- R11: A read sampled on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| addr | input | AW | Word address |
| glob_wr_n | input | 1 | Global write, active low, writes all bytes |
| byte_wr_en_n | input | 1 | Active-low qualifier for the per-byte write strobes |
| byte_wr_n | input | NB | Per-byte write strobes, active low, bit i covers byte i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| dq_i | input | DW | Write data from the shared bus |
| dq_o | output | DW | Read data towards the shared bus |
| dq_oe | output | 1 | Bus drive enable for `dq_o` |

## Verification
A wrong write mask inside the block shows up as a wrong byte lane. That error stays hidden until the address is read again, so the bench follows every write with reads and compares the whole word against a behavioural model on every clock. A wrong wake-up count or pipeline-valid state shows up at `dq_oe` within one or two edges of the request that exposes it. A request that is wrongly accepted during sleep or the wake-up window is caught by the later read of that address, because the read returns data the model never wrote.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  localparam int unsigned LANE_W = 8;

  // Device is selected only with every enable at its active level.
  function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
    return (!a_n) && b && (!c_n);
  endfunction

  // Next value of the wake-up countdown: reload while asleep, else count down to zero.
  function automatic int unsigned wake_next(input int unsigned cur, input logic asleep,
                                            input int unsigned reload);
    if (asleep) return reload;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/pbs_wake_ctl.sv
module pbs_wake_ctl #(
  parameter int unsigned WAKE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(pbs_pkg::wake_next(int'(cnt_q), sleep_i, WAKE_CYC));
  end

  assign ready_o = (cnt_q == '0) && !sleep_i;

  // R8: nothing is accepted while sleep is asserted
  a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !ready_o);

  // R9: the edge right after release still lies inside the wake-up window
  a_r9_window_open: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_i) |-> !ready_o);

endmodule

// File: rtl/pbs_wr_decode.sv
module pbs_wr_decode #(
  parameter int unsigned NB = 4
) (
  input  logic          glob_wr_n,
  input  logic          byte_wr_en_n,
  input  logic [NB-1:0] byte_wr_n,
  output logic [NB-1:0] lane_we
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_we[g] = (!glob_wr_n) || ((!byte_wr_en_n) && (!byte_wr_n[g]));
  end

  // R3: with both qualifiers inactive the strobes cannot reach any lane
  always_comb begin
    if (glob_wr_n && byte_wr_en_n)
      a_r3_strobes_gated: assert (lane_we == '0);
  end

endmodule

// File: rtl/pbs_store.sv
module pbs_store #(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NB-1:0]                  wr_lane_i,
  input  logic                           rd_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [NB*pbs_pkg::LANE_W-1:0]  data_i,
  output logic [NB*pbs_pkg::LANE_W-1:0]  rd_data_o,
  output logic                           rd_vld_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned LW    = pbs_pkg::LANE_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];
    logic [LW-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_lane_i[g]) lane_mem[addr_i] <= data_i[g*LW +: LW];
      if (rd_i)         lane_q           <= lane_mem[addr_i];
    end

    assign rd_data_o[g*LW +: LW] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_o <= 1'b0;
    else        rd_vld_o <= rd_i;
  end

  // R5: a registered request is either a read or a write, never both
  a_r5_op_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && (|wr_lane_i)));

endmodule

// File: rtl/pipe_bw_sram.sv
module pipe_bw_sram #(
  parameter int unsigned AW       = 6,
  parameter int unsigned NB       = 4,
  parameter int unsigned WAKE_CYC = 3,
  localparam int unsigned DW      = NB * pbs_pkg::LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic [AW-1:0] addr,
  input  logic          glob_wr_n,
  input  logic          byte_wr_en_n,
  input  logic [NB-1:0] byte_wr_n,
  input  logic          oe_n,
  input  logic          sleep,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);
  // internal events, named for the assertions
  logic          chip_sel;
  logic          wake_ready;
  logic          req_ok;
  logic [NB-1:0] lane_we;
  logic          acc_wr;
  logic          acc_rd;

  // request register (stage 1)
  logic [NB-1:0] rq_lane_q;
  logic          rq_rd_q;
  logic [AW-1:0] rq_addr_q;
  logic [DW-1:0] rq_data_q;

  // output register (stage 2)
  logic [DW-1:0] rd_data;
  logic          rd_vld;

  assign chip_sel = pbs_pkg::chip_selected(sel_a_n, sel_b, sel_c_n);

  pbs_wake_ctl #(.WAKE_CYC(WAKE_CYC)) i_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_i (sleep),
    .ready_o (wake_ready)
  );

  pbs_wr_decode #(.NB(NB)) i_dec (
    .glob_wr_n    (glob_wr_n),
    .byte_wr_en_n (byte_wr_en_n),
    .byte_wr_n    (byte_wr_n),
    .lane_we      (lane_we)
  );

  assign req_ok = chip_sel && wake_ready;
  assign acc_wr = req_ok && (|lane_we);
  assign acc_rd = req_ok && !(|lane_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_lane_q <= '0;
      rq_rd_q   <= 1'b0;
    end else begin
      rq_lane_q <= acc_wr ? lane_we : '0;
      rq_rd_q   <= acc_rd;
    end
  end

  always_ff @(posedge clk) begin
    rq_addr_q <= addr;
    rq_data_q <= dq_i;
  end

  pbs_store #(.AW(AW), .NB(NB)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lane_i (rq_lane_q),
    .rd_i      (rq_rd_q),
    .addr_i    (rq_addr_q),
    .data_i    (rq_data_q),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld)
  );

  assign dq_o  = rd_data;
  assign dq_oe = (!oe_n) && rd_vld && wake_ready;

  // R6: output enable high releases the bus
  a_r6_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R8: sleep releases the bus
  a_r8_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

  // R7: a deselected cycle leaves no request behind
  a_r7_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> (rq_lane_q == '0) && !rq_rd_q);

  // R5: driven data always stems from a read accepted two edges earlier
  a_r5_drive_source: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(acc_rd, 2));

endmodule

// File: tb/test_pipe_bw_sram.sv
module test_pipe_bw_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic        glob_wr_n = 1'b1, byte_wr_en_n = 1'b1;
  logic [3:0]  byte_wr_n = 4'hF;
  logic        oe_n = 1'b0, sleep = 1'b0;
  logic [31:0] dq_i = '0;
  logic [31:0] dq_o;
  logic        dq_oe;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_bw_sram #(.AW(AW), .NB(4), .WAKE_CYC(3)) i_pipe_bw_sram (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .addr(addr), .glob_wr_n(glob_wr_n), .byte_wr_en_n(byte_wr_en_n), .byte_wr_n(byte_wr_n),
    .oe_n(oe_n), .sleep(sleep), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("[TB] FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_wake = 0;
  bit          p1_rd = 0;
  bit  [3:0]   p1_we = 0;
  int          p1_a = 0;
  logic [31:0] p1_d = 0;
  bit          p2_v = 0;
  bit          p2_k = 0;
  logic [31:0] p2_d = 0;
  logic [31:0] mm [DEPTH];
  bit          mk [DEPTH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wake = 0; p1_rd = 0; p1_we = 0; p2_v = 0;
    end else begin
      bit ready, selected;
      bit [3:0] we;
      p2_v = p1_rd;
      if (p1_rd) begin p2_d = mm[p1_a]; p2_k = mk[p1_a]; end
      for (int b = 0; b < 4; b++)
        if (p1_we[b]) mm[p1_a][8*b +: 8] = p1_d[8*b +: 8];
      if (p1_we == 4'hF) mk[p1_a] = 1;
      ready    = (m_wake == 0) && !sleep;
      selected = (sel_a_n == 0) && (sel_b == 1) && (sel_c_n == 0);
      if (!glob_wr_n)         we = 4'hF;
      else if (!byte_wr_en_n) we = ~byte_wr_n;
      else                    we = 4'h0;
      p1_we = (selected && ready) ? we : 4'h0;
      p1_rd = selected && ready && (we == 0);
      p1_a  = int'(addr);
      p1_d  = dq_i;
      if (sleep) m_wake = 3;
      else if (m_wake > 0) m_wake = m_wake - 1;
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    #3;
    if (cmp_on) begin
      bit exp_oe;
      exp_oe = !oe_n && p2_v && (m_wake == 0) && !sleep;
      chk("R5/R6/R8 cycle dq_oe", {31'd0, dq_oe}, {31'd0, exp_oe});
      if (exp_oe && p2_k) chk("R5 cycle dq_o", dq_o, p2_d);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic go_idle();
    sel_a_n = 1; sel_b = 1; sel_c_n = 0; glob_wr_n = 1; byte_wr_en_n = 1; byte_wr_n = 4'hF;
  endtask

  task automatic sel_on();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
  endtask

  task automatic wr_glob(input int a, input logic [31:0] d);
    @(negedge clk);
    sel_on(); addr = AW'(a); dq_i = d; glob_wr_n = 0; byte_wr_en_n = 1; byte_wr_n = 4'hF;
  endtask

  task automatic wr_bytes(input int a, input logic [31:0] d, input logic [3:0] strobe_n);
    @(negedge clk);
    sel_on(); addr = AW'(a); dq_i = d; glob_wr_n = 1; byte_wr_en_n = 0; byte_wr_n = strobe_n;
  endtask

  task automatic rd_issue(input int a);
    @(negedge clk);
    sel_on(); addr = AW'(a); glob_wr_n = 1; byte_wr_en_n = 1; byte_wr_n = 4'hF;
  endtask

  task automatic rd_check(input int a, input logic [31:0] exp, input string tag);
    rd_issue(a);
    @(negedge clk); go_idle();
    @(negedge clk); go_idle();
    chk({tag, " oe"}, {31'd0, dq_oe}, 32'd1);
    chk(tag, dq_o, exp);
  endtask

  function automatic logic [31:0] init_val(input int i);
    return {8'(i), 8'(i ^ 8'h5A), 8'(~i), 8'(i + 3)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("[TB] FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    go_idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 dq_oe after reset", {31'd0, dq_oe}, 32'd0);
    cmp_on = 1;

    for (int i = 0; i < DEPTH; i++) wr_glob(i, init_val(i));
    @(negedge clk); go_idle();

    // R1: requests accepted right after reset (first read is good)
    rd_check(0, init_val(0), "R1 first read");

    // R4: global write overrides disabled lane strobes
    wr_glob(5, 32'hCAFE_F00D);
    @(negedge clk); go_idle();
    rd_check(5, 32'hCAFE_F00D, "R4 global write");

    // R2: lane 2 only (bits 23:16)
    wr_bytes(6, 32'h1122_3344, 4'b1011);
    @(negedge clk); go_idle();
    rd_check(6, (init_val(6) & 32'hFF00_FFFF) | 32'h0022_0000, "R2 lane2 write");
    // R2: lanes 0 and 3
    wr_bytes(7, 32'hAABB_CCDD, 4'b0110);
    @(negedge clk); go_idle();
    rd_check(7, (init_val(7) & 32'h00FF_FF00) | 32'hAA00_00DD, "R2 lanes0/3 write");

    // R3: strobes without qualifier do nothing
    @(negedge clk);
    sel_on(); addr = 8; dq_i = 32'h0; glob_wr_n = 1; byte_wr_en_n = 1; byte_wr_n = 4'h0;
    @(negedge clk); go_idle();
    rd_check(8, init_val(8), "R3 unqualified strobes");

    // R11: write followed at once by read of same address
    wr_glob(9, 32'h1357_9BDF);
    rd_issue(9);
    @(negedge clk); go_idle();
    @(negedge clk);
    chk("R11 read after write", dq_o, 32'h1357_9BDF);

    // R6: asynchronous output enable
    rd_issue(10);
    @(negedge clk); go_idle();
    @(negedge clk);
    oe_n = 1; #1;
    chk("R6 oe_n high", {31'd0, dq_oe}, 32'd0);
    oe_n = 0; #1;
    chk("R6 oe_n low again", {31'd0, dq_oe}, 32'd1);

    // R7: each select inactive blocks a write
    @(negedge clk); sel_a_n = 1; sel_b = 1; sel_c_n = 0; addr = 11; dq_i = 32'hBAD0_0001; glob_wr_n = 0;
    @(negedge clk); sel_a_n = 0; sel_b = 0; sel_c_n = 0; addr = 12; dq_i = 32'hBAD0_0002; glob_wr_n = 0;
    @(negedge clk); sel_a_n = 0; sel_b = 1; sel_c_n = 1; addr = 13; dq_i = 32'hBAD0_0003; glob_wr_n = 0;
    @(negedge clk); go_idle();
    @(negedge clk);
    chk("R7 deselected slot", {31'd0, dq_oe}, 32'd0);
    rd_check(11, init_val(11), "R7 sel_a_n blocks");
    rd_check(12, init_val(12), "R7 sel_b blocks");
    rd_check(13, init_val(13), "R7 sel_c_n blocks");

    // R8/R9/R10: sleep, wake window, retention
    rd_issue(14);
    @(negedge clk); go_idle();
    sleep = 1; #1;
    chk("R8 sleep releases bus", {31'd0, dq_oe}, 32'd0);
    wr_glob(39, 32'hDEAD_0039);
    @(negedge clk); go_idle();
    @(negedge clk);
    wr_glob(40, 32'hDEAD_0040); sleep = 0;
    wr_glob(41, 32'hDEAD_0041);
    wr_glob(42, 32'hDEAD_0042);
    wr_glob(43, 32'hDEAD_0043);
    @(negedge clk); go_idle();
    rd_check(39, init_val(39), "R8 write in sleep ignored");
    rd_check(40, init_val(40), "R9 window edge 1 ignored");
    rd_check(41, init_val(41), "R9 window edge 2 ignored");
    rd_check(42, init_val(42), "R9 window edge 3 ignored");
    rd_check(43, 32'hDEAD_0043, "R9 fourth edge accepted");
    rd_check(20, init_val(20), "R10 retained through sleep");

    // random traffic against the model
    begin
      int sleep_left = 0;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if ($urandom % 8 != 0) sel_on();
        else begin sel_a_n = 1'($urandom); sel_b = 1'($urandom); sel_c_n = 1'($urandom); end
        addr = AW'($urandom);
        dq_i = $urandom;
        glob_wr_n = ($urandom % 4 != 0);
        byte_wr_en_n = 1'($urandom);
        byte_wr_n = 4'($urandom);
        oe_n = ($urandom % 8 == 0);
        if (sleep_left > 0) sleep_left--;
        else if ($urandom % 100 == 0) sleep_left = 1 + int'($urandom % 4);
        sleep = (sleep_left > 0);
      end
    end
    @(negedge clk); go_idle(); sleep = 0; oe_n = 0;
    repeat (6) @(negedge clk);
    cmp_on = 0;

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule